// File: doc/BRIEF.md
# Segment Base-Limit Translator

This block turns a segmented virtual address into a physical address. A request carries a segment selector, an offset and an access kind. The selector picks one of eight descriptors. Each descriptor holds a physical base, a length limit, read/write/execute permission bits and a present bit. The block checks that the segment is present, that the offset lies inside the segment, and that the segment allows the requested kind of access. If all three checks pass, it returns base plus offset. Otherwise it returns a fault code.

Descriptors are loaded through a plain write port, one descriptor per cycle. Requests and responses are valid/ready streams. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Its response appears, registered, on the next cycle. The single output register gives back-pressure. `req_ready` is high whenever the output register is empty or is being drained in that cycle. While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and no new request is taken.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1 and every descriptor is marked not present.
- R2: A cycle with `cfg_we` high loads the descriptor chosen by `cfg_sel` with base, limit, permission bits and present bit. The other seven descriptors are left unchanged.
- R3: For a present segment, an in-bounds offset and a permitted access, the response has fault code 0 and address (base + offset) modulo 2^PA_W.
- R4: An offset greater than or equal to the segment limit gives fault code 2. A limit of 0 makes every offset fault.
- R5: Access code 0 (read) needs the read bit, code 1 (write) needs the write bit and code 2 (execute) needs the execute bit. Code 3 is never permitted. A missing permission gives fault code 3.
- R6: Selecting a descriptor whose present bit is clear gives fault code 1, whatever the offset and access.
- R7: When several faults apply, the code reported follows the order not-present (1), then out-of-bounds (2), then rights (3).
- R8: A response with a non-zero fault code carries address 0.
- R9: `rsp_valid` rises on the cycle after a request is accepted.
- R10: `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_addr` and `rsp_fault` stay unchanged.
- R11: A request accepted in the same cycle as a descriptor write to its segment is translated with the old descriptor. The new descriptor applies from the next request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_sel | input | 3 | Descriptor index to write |
| cfg_base | input | 20 | Physical base of the segment |
| cfg_limit | input | 17 | Segment length; valid offsets are below it |
| cfg_present | input | 1 | Descriptor present bit |
| cfg_rd | input | 1 | Read permission |
| cfg_wr | input | 1 | Write permission |
| cfg_ex | input | 1 | Execute permission |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_sel | input | 3 | Segment selector |
| req_ofs | input | 16 | Offset within segment |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 20 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 out of bounds, 3 rights |

## Verification
The assertions check the stream behaviour on every cycle. They check that the ready rule holds, that a response is held stable under back-pressure, that a response follows every accepted request one cycle later, and that a faulted response carries address 0. Two fault classes are also tied to the descriptor seen at acceptance: out-of-bounds and not-present. The rest can only be shown by the bench's scenarios: the computed address values, wrap-around of the sum, the permission table including the reserved access code, fault priority, the independence of the eight descriptors, and the rule that a write in the same cycle as a request reaches only later requests.

// File: rtl/seg_xlate_pkg.sv
`timescale 1ns/1ps
package seg_xlate_pkg;

  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_EX = 2'd2;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_BOUNDS = 2'd2,
    FLT_RIGHTS = 2'd3
  } flt_e;

  typedef struct packed {
    logic present;
    logic rd;
    logic wr;
    logic ex;
  } seg_attr_t;

endpackage

// File: rtl/seg_desc_bank.sv
`timescale 1ns/1ps
module seg_desc_bank
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int PA_W    = 20,
  parameter int LIM_W   = 17,
  localparam int SEL_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [LIM_W-1:0] wr_limit,
  input  seg_attr_t        wr_attr,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [PA_W-1:0]  rd_base,
  output logic [LIM_W-1:0] rd_limit,
  output seg_attr_t        rd_attr
);

  logic [PA_W-1:0]  base_q  [NUM_SEG];
  logic [LIM_W-1:0] limit_q [NUM_SEG];
  seg_attr_t        attr_q  [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_sel == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
        attr_q[g]  <= '0;
      end else if (hit) begin
        base_q[g]  <= wr_base;
        limit_q[g] <= wr_limit;
        attr_q[g]  <= wr_attr;
      end
    end
  end

  // Selectors beyond the populated range read as an absent descriptor.
  always_comb begin
    rd_base  = '0;
    rd_limit = '0;
    rd_attr  = '0;
    if (int'(rd_sel) < NUM_SEG) begin
      rd_base  = base_q[rd_sel];
      rd_limit = limit_q[rd_sel];
      rd_attr  = attr_q[rd_sel];
    end
  end

endmodule

// File: rtl/seg_check.sv
`timescale 1ns/1ps
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int OFS_W = 16,
  parameter int PA_W  = 20,
  parameter int LIM_W = 17
) (
  input  logic [PA_W-1:0]  base,
  input  logic [LIM_W-1:0] limit,
  input  seg_attr_t        attr,
  input  logic [OFS_W-1:0] ofs,
  input  logic [1:0]       acc,
  output flt_e             fault,
  output logic [PA_W-1:0]  addr
);

  logic in_bounds;
  logic allowed;

  assign in_bounds = LIM_W'(ofs) < limit;

  always_comb begin
    unique case (acc)
      ACC_RD:  allowed = attr.rd;
      ACC_WR:  allowed = attr.wr;
      ACC_EX:  allowed = attr.ex;
      default: allowed = 1'b0;
    endcase
  end

  // Priority: absent, then bounds, then rights.
  always_comb begin
    if (!attr.present)   fault = FLT_ABSENT;
    else if (!in_bounds) fault = FLT_BOUNDS;
    else if (!allowed)   fault = FLT_RIGHTS;
    else                 fault = FLT_NONE;
  end

  assign addr = base + PA_W'(ofs);

endmodule

// File: rtl/seg_resp_reg.sv
`timescale 1ns/1ps
module seg_resp_reg
  import seg_xlate_pkg::*;
#(
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PA_W-1:0] in_addr,
  input  flt_e            in_fault,
  input  logic            rsp_ready,
  output logic            rsp_valid,
  output logic [PA_W-1:0] rsp_addr,
  output flt_e            rsp_fault
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_fault <= FLT_NONE;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_addr  <= (in_fault == FLT_NONE) ? in_addr : '0;
      rsp_fault <= in_fault;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_fault)));

  p_fault_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_addr == '0));

endmodule

// File: rtl/seg_xlate.sv
`timescale 1ns/1ps
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int OFS_W   = 16,
  parameter int PA_W    = 20,
  localparam int LIM_W  = OFS_W + 1,
  localparam int SEL_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [PA_W-1:0]  cfg_base,
  input  logic [LIM_W-1:0] cfg_limit,
  input  logic             cfg_present,
  input  logic             cfg_rd,
  input  logic             cfg_wr,
  input  logic             cfg_ex,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [OFS_W-1:0] req_ofs,
  input  logic [1:0]       req_acc,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_addr,
  output logic [1:0]       rsp_fault
);

  seg_attr_t        wr_attr;
  logic [PA_W-1:0]  d_base;
  logic [LIM_W-1:0] d_limit;
  seg_attr_t        d_attr;
  flt_e             chk_fault;
  logic [PA_W-1:0]  chk_addr;
  flt_e             out_fault;
  logic             accept;

  assign wr_attr = '{present: cfg_present, rd: cfg_rd, wr: cfg_wr, ex: cfg_ex};

  seg_desc_bank #(.NUM_SEG(NUM_SEG), .PA_W(PA_W), .LIM_W(LIM_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_sel   (cfg_sel),
    .wr_base  (cfg_base),
    .wr_limit (cfg_limit),
    .wr_attr  (wr_attr),
    .rd_sel   (req_sel),
    .rd_base  (d_base),
    .rd_limit (d_limit),
    .rd_attr  (d_attr)
  );

  seg_check #(.OFS_W(OFS_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_check (
    .base  (d_base),
    .limit (d_limit),
    .attr  (d_attr),
    .ofs   (req_ofs),
    .acc   (req_acc),
    .fault (chk_fault),
    .addr  (chk_addr)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  seg_resp_reg #(.PA_W(PA_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .in_addr   (chk_addr),
    .in_fault  (chk_fault),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_addr  (rsp_addr),
    .rsp_fault (out_fault)
  );

  assign rsp_fault = out_fault;

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_absent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !d_attr.present) |=> (rsp_fault == FLT_ABSENT));

  p_bounds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && d_attr.present && (LIM_W'(req_ofs) >= d_limit)) |=> (rsp_fault == FLT_BOUNDS));

endmodule

// File: tb/seg_xlate_test.sv
`timescale 1ns/1ps
module seg_xlate_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [19:0] cfg_base = '0;
  logic [16:0] cfg_limit = '0;
  logic        cfg_present = 1'b0, cfg_rd = 1'b0, cfg_wr = 1'b0, cfg_ex = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_sel = '0;
  logic [15:0] req_ofs = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [19:0] rsp_addr;
  logic [1:0]  rsp_fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int unsigned m_base [8];
  int unsigned m_lim  [8];
  bit          m_p [8], m_r [8], m_w [8], m_x [8];

  always #2.5 clk = ~clk;

  seg_xlate uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
    .cfg_present(cfg_present), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_ex(cfg_ex),
    .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel),
    .req_ofs(req_ofs), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault)
  );

  function automatic int unsigned exp_fault(int sel, int unsigned ofs, int acc);
    bit perm;
    if (!m_p[sel]) return 1;
    if (ofs >= m_lim[sel]) return 2;
    case (acc)
      0: perm = m_r[sel];
      1: perm = m_w[sel];
      2: perm = m_x[sel];
      default: perm = 1'b0;
    endcase
    return perm ? 0 : 3;
  endfunction

  function automatic int unsigned exp_addr(int sel, int unsigned ofs, int acc);
    if (exp_fault(sel, ofs, acc) != 0) return 0;
    return (m_base[sel] + ofs) & 32'hFFFFF;
  endfunction

  task automatic chk(string tag, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic load_model(int sel, int unsigned base, int unsigned lim, bit p, bit r, bit w, bit x);
    m_base[sel] = base & 32'hFFFFF; m_lim[sel] = lim & 32'h1FFFF;
    m_p[sel] = p; m_r[sel] = r; m_w[sel] = w; m_x[sel] = x;
  endtask

  task automatic drive_cfg(int sel, int unsigned base, int unsigned lim, bit p, bit r, bit w, bit x);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_base = 20'(base); cfg_limit = 17'(lim);
    cfg_present = p; cfg_rd = r; cfg_wr = w; cfg_ex = x;
  endtask

  task automatic write_desc(int sel, int unsigned base, int unsigned lim, bit p, bit r, bit w, bit x);
    @(negedge clk);
    drive_cfg(sel, base, lim, p, r, w, x);
    @(posedge clk);
    #1 cfg_we = 1'b0;
    load_model(sel, base, lim, p, r, w, x);
  endtask

  task automatic xlate(int sel, int unsigned ofs, int acc, string tag);
    int unsigned ef, ea;
    @(negedge clk);
    ef = exp_fault(sel, ofs, acc);
    ea = exp_addr(sel, ofs, acc);
    req_valid = 1'b1; req_sel = 3'(sel); req_ofs = 16'(ofs); req_acc = 2'(acc);
    rsp_ready = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    chk({tag, " R9 valid"}, rsp_valid, 1);
    chk({tag, " fault"}, rsp_fault, ef);
    chk({tag, " addr"}, rsp_addr, ea);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int unsigned ea, eb;
    void'($urandom(32'h1234_5eed));
    for (int i = 0; i < 8; i++) load_model(i, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 rsp_valid after reset", rsp_valid, 0);
    chk("R1 req_ready after reset", req_ready, 1);
    xlate(0, 0, 0, "R1 seg0 absent after reset");
    xlate(7, 16'h1234, 2, "R1 seg7 absent after reset");

    // R2 / R3 / R4 / R5 / R7 directed
    write_desc(1, 32'h12000, 32'h100, 1, 1, 0, 0);
    xlate(1, 16'h00FF, 0, "R3 last in-bounds read");
    xlate(1, 16'h0000, 0, "R3 offset zero");
    xlate(1, 16'h0100, 0, "R4 offset equals limit");
    xlate(1, 16'h0010, 1, "R5 write on read-only");
    xlate(1, 16'h0010, 2, "R5 exec on read-only");
    xlate(1, 16'h0010, 3, "R5 reserved access code");
    xlate(1, 16'h0200, 1, "R7 bounds before rights");

    write_desc(2, 32'hFFFF0, 32'h10000, 1, 1, 1, 1);
    xlate(2, 16'h0020, 0, "R3 wrap of base plus offset");
    xlate(2, 16'hFFFF, 1, "R3 max offset full segment");
    xlate(2, 16'h0001, 2, "R5 exec permitted");
    xlate(2, 16'h0001, 3, "R5 reserved code with all bits");

    write_desc(3, 32'h40000, 0, 1, 1, 1, 1);
    xlate(3, 16'h0000, 0, "R4 zero limit");

    write_desc(4, 32'h50000, 32'h10000, 0, 1, 1, 1);
    xlate(4, 16'h0004, 0, "R6 absent with wide limit");
    xlate(4, 16'hFFFF, 3, "R7 absent before other faults");
    xlate(4, 16'h0004, 1, "R8 address zero on absent");

    // R2 isolation: seg1 still as written
    xlate(1, 16'h0040, 0, "R2 other entries unchanged");
    write_desc(1, 32'h00300, 32'h20, 1, 0, 1, 0);
    xlate(1, 16'h001F, 1, "R2 rewrite takes effect");
    xlate(2, 16'h0020, 0, "R2 neighbour unaffected");

    // R11 same-cycle write and request
    @(negedge clk);
    ea = exp_fault(5, 16'h10, 0);
    req_valid = 1'b1; req_sel = 3'd5; req_ofs = 16'h10; req_acc = 2'd0; rsp_ready = 1'b1;
    drive_cfg(5, 32'h60000, 32'h100, 1, 1, 0, 0);
    @(posedge clk);
    #1 req_valid = 1'b0; cfg_we = 1'b0;
    load_model(5, 32'h60000, 32'h100, 1, 1, 0, 0);
    @(negedge clk);
    chk("R11 old descriptor used fault", rsp_fault, ea);
    chk("R11 old descriptor used addr", rsp_addr, 0);
    xlate(5, 16'h10, 0, "R11 new descriptor next request");

    // R10 back-pressure
    @(negedge clk);
    ea = exp_addr(2, 16'h0005, 0);
    eb = exp_addr(2, 16'h0006, 0);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_sel = 3'd2; req_ofs = 16'h0005; req_acc = 2'd0;
    @(posedge clk);
    #1 req_ofs = 16'h0006;
    @(negedge clk);
    chk("R10 stalled valid", rsp_valid, 1);
    chk("R10 ready low when stalled", req_ready, 0);
    chk("R10 first addr", rsp_addr, ea);
    @(posedge clk);
    @(negedge clk);
    chk("R10 addr held", rsp_addr, ea);
    chk("R10 fault held", rsp_fault, 0);
    rsp_ready = 1'b1;
    #0.1 chk("R10 ready follows rsp_ready", req_ready, 1);
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    chk("R10 second accepted valid", rsp_valid, 1);
    chk("R10 second addr", rsp_addr, eb);
    @(negedge clk);
    chk("R9 valid drops when drained", rsp_valid, 0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int sel;
      int unsigned ofs;
      if (($urandom % 8) == 0) begin
        sel = $urandom % 8;
        write_desc(sel, $urandom, ($urandom % 4 == 0) ? ($urandom % 3) : ($urandom % 32'h10001),
                   ($urandom % 5) != 0, $urandom % 2, $urandom % 2, $urandom % 2);
      end else begin
        sel = $urandom % 8;
        if ($urandom % 2) ofs = $urandom % (m_lim[sel] + 2);
        else ofs = $urandom;
        ofs = ofs & 32'hFFFF;
        xlate(sel, ofs, $urandom % 4, "R3 R4 R5 R6 random");
      end
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule